// File: doc/BRIEF.md
# Boot Window Command Decoder

This block sits behind the register write bus of a bootable flash device. It watches host writes that land in the boot buffer window and treats the written value as a boot command. Three commands are recognised:

- **Warm-reset request.** A one-cycle pulse is raised for the device's reset logic.
- **Two-step page load.** The sector number of the start of a page is formed from the block and page address registers. The block then issues a one-page load request to an external array reader, which fills data buffer 0. The page register then moves on to the next page.
- **Identification.** The manufacturer code, the device code and the low byte of the write-protection status are placed, zero-extended to full words, into the first three words of the boot buffer through a word write port.

The block also owns the block and page address registers. Both are written over the same bus. The page register is visible on a port so that the host side can see it advance.

The array read itself happens outside the block. The block holds a request with the sector number until the reader acknowledges it. While a request is outstanding, or while the identification words are being written, further boot-window writes are discarded.

Top module: `boot_cmd_decoder`

## Requirements
- R1: Only writes whose offset lies in 0x0000–0x01FF or in 0x8000–0x800F are taken as boot commands. A write to any other offset never raises a reset pulse, a load request or a buffer write.
- R2: A boot write of 0x00F0, when no load is armed, raises `resetReq` for exactly one cycle, in the cycle after the write.
- R3: A boot write of 0x00E0 arms the load. If the next boot write is 0x0000, `loadReq` rises in the cycle after that second write, and `loadSector` carries the sector of the page.
- R4: If the boot write following 0x00E0 is any value other than 0x0000, the arm is cleared. That value is not decoded as a command, and no load follows.
- R5: Each load request adds 4 to the page register (the written value at offset 0xF107) and keeps only its low 8 bits. The upper bits become zero.
- R6: The sector is page[1:0] + ((page[7:2] + (B << 6)) << 2). B is block[11:0] (the block register at offset 0xF100), ORed with the density mask when block bit 15 is set.
- R7: A boot write of 0x0090 causes three buffer writes in consecutive cycles, starting the cycle after the write:
  - word 0 receives {8'h00, manufacturer}
  - word 1 receives {8'h00, device}
  - word 2 receives {8'h00, write-protect low byte}
- R8: A first-step boot write of any value other than 0x00F0, 0x00E0 or 0x0090 has no effect.
- R9: `loadReq` and `loadSector` hold until `loadAck` is seen, and `loadReq` falls in the cycle after the acknowledge. Boot writes that arrive while the load is pending are dropped.
- R10: The reset input clears `loadReq`, `resetReq`, the buffer write enable, both address registers and the load arm. A 0x0000 after a reset that followed 0x00E0 starts no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrOffset | input | 16 | Host write word offset |
| wrData | input | 16 | Host write data |
| mfrId | input | 8 | Manufacturer code |
| devId | input | 8 | Device code |
| wpStatusLo | input | 8 | Low byte of write-protection status |
| loadAck | input | 1 | Array reader accepts the pending load |
| loadReq | output | 1 | One-page load request into data buffer 0 |
| loadSector | output | BLOCK_BITS+PAGE_BITS+SPP_LOG2 | First sector of the page to load |
| resetReq | output | 1 | One-cycle warm-reset request |
| bufWrEn | output | 1 | Boot buffer word write enable |
| bufWrAddr | output | 2 | Boot buffer word index |
| bufWrData | output | 16 | Boot buffer word data |
| pageAddr | output | 16 | Current page address register |

## Verification
The bench builds the block with a density mask of 0x200, 12 block bits, 6 page bits and 4 sectors per page. These values make the density fold visible as a changed sector bit whenever block bit 15 is set. The 8-bit page wrap is reached within one increment from page values near 0xFF. Random block and page values cover carries from the sector-in-page field into the page field and from the page field into the block field. Directed cases walk both ends of both boot windows and the offsets just outside them.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;

  localparam int REG_ADDR_W = 16;

  localparam logic [15:0] CMD_WARM_RESET = 16'h00F0;
  localparam logic [15:0] CMD_LOAD_ARM   = 16'h00E0;
  localparam logic [15:0] CMD_IDENTIFY   = 16'h0090;
  localparam logic [15:0] CMD_LOAD_GO    = 16'h0000;

  localparam int ID_WORDS = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAIT,
    ST_IDWR
  } ctrlState_e;

  typedef struct packed {
    logic       captureLoad;
    logic       idWrite;
    logic [1:0] idIndex;
  } dpStrobe_t;

  function automatic logic inBootWindow(input logic [REG_ADDR_W-1:0] off);
    return (off < 16'h0200) || (off[15:4] == 12'h800);
  endfunction

endpackage

// File: rtl/boot_cmd_ctrl.sv
module boot_cmd_ctrl
  import boot_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadAck,
  output logic              loadReq,
  output logic              resetReq,
  output dpStrobe_t         strobe
);

  localparam logic [1:0] ID_LAST = 2'(ID_WORDS - 1);

  ctrlState_e state;
  logic [1:0] idCnt;
  logic       goWrite;
  logic [15:0] cmdVal;

  assign cmdVal  = 16'(wrData);
  assign goWrite = (state == ST_ARMED) && bootWr && (cmdVal == CMD_LOAD_GO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      loadReq  <= 1'b0;
      resetReq <= 1'b0;
      idCnt    <= 2'd0;
    end else begin
      resetReq <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (bootWr) begin
            if (cmdVal == CMD_WARM_RESET) begin
              resetReq <= 1'b1;
            end else if (cmdVal == CMD_LOAD_ARM) begin
              state <= ST_ARMED;
            end else if (cmdVal == CMD_IDENTIFY) begin
              state <= ST_IDWR;
              idCnt <= 2'd0;
            end
          end
        end
        ST_ARMED: begin
          if (bootWr) begin
            if (cmdVal == CMD_LOAD_GO) begin
              state   <= ST_WAIT;
              loadReq <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_WAIT: begin
          if (loadAck) begin
            loadReq <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_IDWR: begin
          idCnt <= idCnt + 2'd1;
          if (idCnt == ID_LAST) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.captureLoad = goWrite;
    strobe.idWrite     = (state == ST_IDWR);
    strobe.idIndex     = idCnt;
  end

  assert_load_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !loadAck) |=> loadReq);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(loadReq && strobe.idWrite));

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && bootWr && cmdVal != CMD_LOAD_GO) |=> (!loadReq && state == ST_IDLE));

endmodule

// File: rtl/boot_cmd_datapath.sv
module boot_cmd_datapath
  import boot_cmd_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          BLOCK_BITS   = 12,
  parameter int          PAGE_BITS    = 6,
  parameter int          SPP_LOG2     = 2,
  parameter int unsigned DENSITY_MASK = 'h100,
  parameter logic [REG_ADDR_W-1:0] BLOCK_REG_OFF = 16'hF100,
  parameter logic [REG_ADDR_W-1:0] PAGE_REG_OFF  = 16'hF107
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrOffset,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [7:0]            mfrId,
  input  logic [7:0]            devId,
  input  logic [7:0]            wpStatusLo,
  input  dpStrobe_t             strobe,
  output logic [BLOCK_BITS+PAGE_BITS+SPP_LOG2-1:0] loadSector,
  output logic                  bufWrEn,
  output logic [1:0]            bufWrAddr,
  output logic [DATA_W-1:0]     bufWrData,
  output logic [DATA_W-1:0]     pageAddr
);

  localparam int SEC_W      = BLOCK_BITS + PAGE_BITS + SPP_LOG2;
  localparam int WRAP_BITS  = PAGE_BITS + SPP_LOG2;
  localparam logic [DATA_W-1:0] PAGE_STEP = DATA_W'(1) << SPP_LOG2;
  localparam logic [DATA_W-1:0] WRAP_MASK = (DATA_W'(1) << WRAP_BITS) - DATA_W'(1);
  localparam logic [BLOCK_BITS-1:0] DMASK = BLOCK_BITS'(DENSITY_MASK);

  logic [DATA_W-1:0]     blockReg;
  logic [DATA_W-1:0]     pageReg;
  logic [BLOCK_BITS-1:0] blkEff;
  logic [SEC_W-1:0]      sectorNow;
  logic [SEC_W-1:0]      sectorReg;
  logic                  unusedBlockBits;

  assign unusedBlockBits = ^blockReg[DATA_W-2:BLOCK_BITS];

  assign blkEff = blockReg[BLOCK_BITS-1:0] | (blockReg[DATA_W-1] ? DMASK : '0);

  always_comb begin
    sectorNow = SEC_W'(pageReg[SPP_LOG2-1:0])
              + ((SEC_W'(pageReg[WRAP_BITS-1:SPP_LOG2])
                  + (SEC_W'(blkEff) << PAGE_BITS)) << SPP_LOG2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockReg  <= '0;
      pageReg   <= '0;
      sectorReg <= '0;
    end else begin
      if (wrEn && wrOffset == BLOCK_REG_OFF) begin
        blockReg <= wrData;
      end
      if (strobe.captureLoad) begin
        sectorReg <= sectorNow;
        pageReg   <= (pageReg + PAGE_STEP) & WRAP_MASK;
      end else if (wrEn && wrOffset == PAGE_REG_OFF) begin
        pageReg <= wrData;
      end
    end
  end

  always_comb begin
    bufWrEn   = strobe.idWrite;
    bufWrAddr = strobe.idIndex;
    unique case (strobe.idIndex)
      2'd0:    bufWrData = DATA_W'(mfrId);
      2'd1:    bufWrData = DATA_W'(devId);
      default: bufWrData = DATA_W'(wpStatusLo);
    endcase
  end

  assign loadSector = sectorReg;
  assign pageAddr   = pageReg;

  assert_page_adv_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureLoad |=> pageReg == (($past(pageReg) + PAGE_STEP) & WRAP_MASK));

  assert_id_seq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.idWrite && strobe.idIndex != 2'(ID_WORDS - 1))
      |=> (strobe.idWrite && strobe.idIndex == $past(strobe.idIndex) + 2'd1));

endmodule

// File: rtl/boot_cmd_decoder.sv
module boot_cmd_decoder
  import boot_cmd_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          BLOCK_BITS   = 12,
  parameter int          PAGE_BITS    = 6,
  parameter int          SPP_LOG2     = 2,
  parameter int unsigned DENSITY_MASK = 'h100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrOffset,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [7:0]            mfrId,
  input  logic [7:0]            devId,
  input  logic [7:0]            wpStatusLo,
  input  logic                  loadAck,
  output logic                  loadReq,
  output logic [BLOCK_BITS+PAGE_BITS+SPP_LOG2-1:0] loadSector,
  output logic                  resetReq,
  output logic                  bufWrEn,
  output logic [1:0]            bufWrAddr,
  output logic [DATA_W-1:0]     bufWrData,
  output logic [DATA_W-1:0]     pageAddr
);

  logic      bootWr;
  dpStrobe_t strobe;

  assign bootWr = wrEn && inBootWindow(wrOffset);

  boot_cmd_ctrl #(
    .DATA_W (DATA_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .bootWr   (bootWr),
    .wrData   (wrData),
    .loadAck  (loadAck),
    .loadReq  (loadReq),
    .resetReq (resetReq),
    .strobe   (strobe)
  );

  boot_cmd_datapath #(
    .DATA_W       (DATA_W),
    .BLOCK_BITS   (BLOCK_BITS),
    .PAGE_BITS    (PAGE_BITS),
    .SPP_LOG2     (SPP_LOG2),
    .DENSITY_MASK (DENSITY_MASK)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrOffset   (wrOffset),
    .wrData     (wrData),
    .mfrId      (mfrId),
    .devId      (devId),
    .wpStatusLo (wpStatusLo),
    .strobe     (strobe),
    .loadSector (loadSector),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData),
    .pageAddr   (pageAddr)
  );

  assert_sector_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !loadAck) |=> $stable(loadSector));

  assert_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inBootWindow(wrOffset) && !loadReq && !bufWrEn) |=> (!resetReq && !loadReq));

endmodule

// File: tb/boot_cmd_decoder_tb.sv
module boot_cmd_decoder_tb_top;

  localparam int DW  = 16;
  localparam int BB  = 12;
  localparam int PB  = 6;
  localparam int SP  = 2;
  localparam int SW  = BB + PB + SP;
  localparam int unsigned DM = 'h200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [15:0]   wrOffset = '0;
  logic [DW-1:0] wrData = '0;
  logic [7:0]    mfrId = 8'hEC;
  logic [7:0]    devId = 8'h48;
  logic [7:0]    wpStatusLo = 8'h34;
  logic          loadAck = 1'b0;
  logic          loadReq;
  logic [SW-1:0] loadSector;
  logic          resetReq;
  logic          bufWrEn;
  logic [1:0]    bufWrAddr;
  logic [DW-1:0] bufWrData;
  logic [DW-1:0] pageAddr;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  boot_cmd_decoder #(
    .DATA_W(DW), .BLOCK_BITS(BB), .PAGE_BITS(PB), .SPP_LOG2(SP), .DENSITY_MASK(DM)
  ) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOffset(wrOffset), .wrData(wrData),
    .mfrId(mfrId), .devId(devId), .wpStatusLo(wpStatusLo), .loadAck(loadAck),
    .loadReq(loadReq), .loadSector(loadSector), .resetReq(resetReq),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .pageAddr(pageAddr)
  );

  function automatic logic [SW-1:0] expSector(input logic [15:0] blk, input logic [15:0] pg);
    logic [BB-1:0] b;
    b = blk[BB-1:0] | (blk[15] ? BB'(DM) : '0);
    return {b, pg[7:0]};
  endfunction

  function automatic logic [15:0] expPageNext(input logic [15:0] pg);
    return {8'h00, pg[7:0] + 8'd4};
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] off, input logic [15:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrOffset = off; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk);
    loadAck = 1'b1;
    @(negedge clk);
    loadAck = 1'b0;
  endtask

  task automatic checkQuiet(input string req);
    check(!loadReq && !bufWrEn && !resetReq, req, {loadReq, bufWrEn, resetReq}, 0);
    @(negedge clk);
    check(!loadReq && !bufWrEn && !resetReq, req, {loadReq, bufWrEn, resetReq}, 0);
  endtask

  task automatic doLoad(input logic [15:0] blk, input logic [15:0] pg,
                        input logic [15:0] off1, input logic [15:0] off2, input int ackDelay);
    logic [SW-1:0] es;
    es = expSector(blk, pg);
    busWrite(16'hF100, blk);
    busWrite(16'hF107, pg);
    busWrite(off1, 16'h00E0);
    busWrite(off2, 16'h0000);
    check(loadReq === 1'b1, "R3 loadReq", loadReq, 1);
    check(loadSector === es, "R6 sector", loadSector, es);
    check(pageAddr === expPageNext(pg), "R5 page advance", pageAddr, expPageNext(pg));
    for (int i = 0; i < ackDelay; i++) begin
      @(negedge clk);
      check(loadReq === 1'b1 && loadSector === es, "R9 held", loadSector, es);
    end
    pulseAck();
    check(loadReq === 1'b0, "R9 release", loadReq, 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(!loadReq && !resetReq && !bufWrEn, "R10 outputs idle", {loadReq, resetReq, bufWrEn}, 0);
    check(pageAddr === 16'h0, "R10 page cleared", pageAddr, 0);

    // R2 reset pulse
    busWrite(16'h0000, 16'h00F0);
    check(resetReq === 1'b1, "R2 pulse", resetReq, 1);
    @(negedge clk);
    check(resetReq === 1'b0, "R2 single cycle", resetReq, 0);

    // R7 identification
    busWrite(16'h800F, 16'h0090);
    check(bufWrEn && bufWrAddr == 2'd0 && bufWrData == 16'h00EC, "R7 word0", bufWrData, 16'h00EC);
    @(negedge clk);
    check(bufWrEn && bufWrAddr == 2'd1 && bufWrData == 16'h0048, "R7 word1", bufWrData, 16'h0048);
    @(negedge clk);
    check(bufWrEn && bufWrAddr == 2'd2 && bufWrData == 16'h0034, "R7 word2", bufWrData, 16'h0034);
    @(negedge clk);
    check(bufWrEn === 1'b0, "R7 done", bufWrEn, 0);

    // R3 R6 R5 R9 directed load with dropped writes while pending
    busWrite(16'hF100, 16'h0123);
    busWrite(16'hF107, 16'h0005);
    busWrite(16'h8003, 16'h00E0);
    busWrite(16'h01FF, 16'h0000);
    check(loadReq === 1'b1, "R3 loadReq", loadReq, 1);
    check(loadSector === expSector(16'h0123, 16'h0005), "R6 sector",
          loadSector, expSector(16'h0123, 16'h0005));
    busWrite(16'h0000, 16'h0090);
    check(bufWrEn === 1'b0 && loadReq === 1'b1, "R9 drop ident", bufWrEn, 0);
    busWrite(16'h0000, 16'h00E0);
    pulseAck();
    check(loadReq === 1'b0, "R9 release", loadReq, 0);
    check(pageAddr === 16'h0009, "R5 page", pageAddr, 16'h0009);
    busWrite(16'h0000, 16'h0000);
    checkQuiet("R9 dropped arm");

    // R6 density fold, R5 wrap and upper clear
    doLoad(16'h8010, 16'h00FE, 16'h0100, 16'h8000, 2);
    doLoad(16'h0FFF, 16'h12FC, 16'h0000, 16'h800F, 0);
    check(pageAddr === 16'h0000, "R5 wrap", pageAddr, 0);

    // R4 disarm: second value not decoded
    busWrite(16'h0010, 16'h00E0);
    busWrite(16'h0010, 16'h0090);
    checkQuiet("R4 no ident");
    busWrite(16'h0010, 16'h0000);
    checkQuiet("R4 no load");

    // R8 other first values ignored
    busWrite(16'h0004, 16'h00AB);
    checkQuiet("R8 ignored");
    busWrite(16'h0004, 16'h0000);
    checkQuiet("R8 zero first");

    // R1 outside the windows
    busWrite(16'h0200, 16'h00F0);
    checkQuiet("R1 0x0200");
    busWrite(16'h7FFF, 16'h0090);
    checkQuiet("R1 0x7FFF");
    busWrite(16'h8010, 16'h00E0);
    busWrite(16'h0000, 16'h0000);
    checkQuiet("R1 0x8010 arm");

    // R10 reset input disarms
    busWrite(16'h0000, 16'h00E0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busWrite(16'h0000, 16'h0000);
    checkQuiet("R10 disarm");
    check(pageAddr === 16'h0000, "R10 page", pageAddr, 0);

    // random loads and ignored values
    for (int n = 0; n < 60; n++) begin
      logic [15:0] blk, pg, o1, o2, v;
      blk = 16'($urandom);
      pg  = 16'($urandom);
      o1 = ($urandom % 2) ? {7'd0, 9'($urandom)} : {12'h800, 4'($urandom)};
      o2 = ($urandom % 2) ? {7'd0, 9'($urandom)} : {12'h800, 4'($urandom)};
      doLoad(blk, pg, o1, o2, int'($urandom % 4));
      v = 16'($urandom);
      if (v == 16'h00F0 || v == 16'h00E0 || v == 16'h0090) v = v ^ 16'h0100;
      busWrite(o1, v);
      checkQuiet("R8 random ignored");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule